// File: doc/BRIEF.md
# Ping-Pong Burst Line Framer

This block frames one 2-wire digital subscriber line that runs in time-compression (ping-pong) mode. Each 250 µs frame is split into two halves of 48 bit periods at a 384 kbit/s line rate. The block is always the timing master. In the first half it sends a burst, and in the second half it listens for the far end's reply. Transmit and receive therefore never overlap on the wire. A frame-sync pulse, given together with a bit-clock enable, marks the first bit period of each frame.

A transmit burst is 20 bits long. It opens with a framing bit that is always '1'. Then come 16 B-channel bits, which pass through a self-synchronizing scrambler, then two D-channel bits and one maintenance (M) bit, both sent in the clear. The line carries zeros for the rest of the frame.

The far end's burst comes back with an unknown line delay. The receiver hunts for the first '1' from the start of the second half. It takes that bit as the burst start and aligns the following 19 bits to the same layout. It descrambles the B field and presents the B, D and M fields together with a one-clock valid strobe. If no start is found, or the burst does not fit before the frame ends, it raises a loss-of-frame flag instead.

Top module: `pp_burst_framer`

## Requirements
- R1: A bit period is one clock with `bit_en` high. `frame_sync` is sampled only in such a clock and makes that bit period slot 0. Otherwise the slot advances by one per bit period and wraps from 95 to 0.
- R2: In slot 0 the block sends the framing bit '1'. `line_tx` is registered and shows the bit of a slot from the clock after that slot's bit-enable clock until the next bit period.
- R3: `tx_b`, `tx_d` and `tx_m` are captured in the slot-0 bit period. Slots 1 to 16 carry the scrambled bits of tx_b, bit 0 first. Slots 17 and 18 carry tx_d[0] then tx_d[1], and slot 19 carries tx_m.
- R4: `line_tx` is 0 in slots 20 to 95, and this includes the whole second half-frame (slots 48 to 95).
- R5: The transmit scrambler sends s = b XOR s(-5) XOR s(-23), where s(-k) is the k-th previous scrambled B bit. Its history holds only B bits, persists across frames and is all zeros after reset.
- R6: `line_rx` is ignored in slots 0 to 47.
- R7: From slot 48 on, the first '1' on `line_rx` is the burst start. The next 16 bits are B, then two D bits, then M, all in transmit order. B is recovered as b = r XOR r(-5) XOR r(-23) over the history of received B bits (zero after reset). D and M are taken as received.
- R8: `rx_valid` is high for exactly one clock, the clock after the bit-enable clock that samples the M bit. `rx_b`, `rx_d` and `rx_m` change only together with that strobe.
- R9: A frame gets no `rx_valid` in two cases: no start is seen, or its M bit would fall after slot 95. In that case `rx_lof` goes to 1 in the clock after the next slot-0 bit period. `rx_lof` returns to 0 together with the next `rx_valid`.
- R10: A synchronous active-low reset drives `line_tx`, `rx_valid`, `rx_lof`, `rx_b`, `rx_d` and `rx_m` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-clock enable per line bit period (384 kHz) |
| frame_sync | input | 1 | Frame start, sampled with bit_en |
| tx_b | input | 16 | B-channel payload to send |
| tx_d | input | 2 | D-channel bits to send |
| tx_m | input | 1 | Maintenance bit to send |
| line_tx | output | 1 | Serial line output |
| line_rx | input | 1 | Serial line input |
| rx_b | output | 16 | Descrambled received B-channel payload |
| rx_d | output | 2 | Received D-channel bits |
| rx_m | output | 1 | Received maintenance bit |
| rx_valid | output | 1 | One-clock strobe: received fields updated |
| rx_lof | output | 1 | Loss of frame on the last completed receive half |

## Verification
Every output is registered once after the bit-enable clock that causes it. The bench raises `bit_en` on a falling edge and samples on the next falling edge, so the line bit and the receive strobes of a slot are read exactly one clock after their cause. The bench checks that the strobe appears in the sampling point of slot 67 plus the injected delay and in no other. `rx_lof` is checked at the sampling point of slot 0, which is where a failed previous frame first shows.

// File: rtl/pp_pkg.sv
// Package: shared constants and types for the ping-pong burst framer.
// Assumes one line per framer instance; the constants are defaults only.
package pp_pkg;
    localparam int FRAME_BITS_DEF = 96;
    localparam int HALF_BITS_DEF  = 48;
    localparam int B_BITS_DEF     = 16;
    localparam int D_BITS_DEF     = 2;
    localparam int SCR_LEN_DEF    = 23;
    localparam int SCR_TAP_DEF    = 5;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_CAPT = 2'd2,
        RX_DONE = 2'd3
    } rx_state_e;
endpackage

// File: rtl/pp_bit_timer.sv
// Module: frame slot counter. It presents the slot number of the current
// bit period. frame_sync forces slot 0; otherwise the slot wraps at
// FRAME_BITS-1. Assumes frame_sync is only meaningful when bit_en is high.
module pp_bit_timer #(
    parameter int FRAME_BITS = 96,
    localparam int SW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          frame_sync,
    output logic [SW-1:0] slot
);
    logic [SW-1:0] cnt_q;

    // Slot of the current bit period: forced by sync, else successor.
    always_comb begin
        if (frame_sync || cnt_q == SW'(FRAME_BITS - 1))
            slot = '0;
        else
            slot = cnt_q + SW'(1);
    end

    // Remember the slot once its bit period has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= SW'(FRAME_BITS - 1);
        else if (bit_en)
            cnt_q <= slot;
    end
endmodule

// File: rtl/pp_scrambler.sv
// Module: self-synchronizing scrambler / descrambler with taps at TAP and
// LEN. With DESCRAMBLE=0 the history holds output bits (scrambler). With
// DESCRAMBLE=1 it holds input bits (descrambler), so it relocks on its own.
// Assumes the history is advanced only for payload bits.
module pp_scrambler #(
    parameter int LEN        = 23,
    parameter int TAP        = 5,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] hist_q;
    logic           fb;

    // Output bit: input mixed with the two tapped history bits.
    assign dout = din ^ hist_q[TAP-1] ^ hist_q[LEN-1];

    // Choose the bit that enters the history according to the variant.
    generate
        if (DESCRAMBLE) begin : g_desc
            assign fb = din;
        end else begin : g_scr
            assign fb = dout;
        end
    endgenerate

    // Shift the history once per payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (adv)
            hist_q <= {hist_q[LEN-2:0], fb};
    end
endmodule

// File: rtl/pp_tx_burst.sv
// Module: transmit burst builder. In slot 0 it sends the framing '1' and
// captures the payload. It then sends scrambled B bits, clear D bits and
// the M bit, and zeros for the rest of the frame. line_tx is registered.
// Assumes tick marks a bit period and slot is that period's frame slot.
module pp_tx_burst #(
    parameter int B_BITS  = 16,
    parameter int D_BITS  = 2,
    parameter int SW      = 7,
    parameter int SCR_LEN = 23,
    parameter int SCR_TAP = 5,
    localparam int PAY = B_BITS + D_BITS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SW-1:0]     slot,
    input  logic [B_BITS-1:0] tx_b,
    input  logic [D_BITS-1:0] tx_d,
    input  logic              tx_m,
    output logic              line_tx
);
    logic [PAY-1:0] pay_q;
    logic           in_b, in_pay, scr_out, nxt;

    // Classify the current slot within the burst.
    assign in_b   = (slot >= SW'(1)) && (slot <= SW'(B_BITS));
    assign in_pay = (slot >= SW'(1)) && (slot <= SW'(PAY));

    pp_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b0)) u_scr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (tick && in_b),
        .din  (pay_q[0]),
        .dout (scr_out)
    );

    // Pick the line bit for the current slot.
    always_comb begin
        if (slot == '0)
            nxt = 1'b1;
        else if (in_b)
            nxt = scr_out;
        else if (in_pay)
            nxt = pay_q[0];
        else
            nxt = 1'b0;
    end

    // Register the line bit; load the payload at slot 0, shift through it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_tx <= 1'b0;
            pay_q   <= '0;
        end else if (tick) begin
            line_tx <= nxt;
            if (slot == '0)
                pay_q <= {tx_m, tx_d, tx_b};
            else if (in_pay)
                pay_q <= pay_q >> 1;
        end
    end
endmodule

// File: rtl/pp_rx_burst.sv
// Module: receive burst aligner. From slot HALF_BITS it hunts for the first
// '1' and then shifts in PAY payload bits; the B part is descrambled. When
// the M bit arrives it updates the fields with a one-clock valid strobe.
// At slot 0 it flags loss of frame if the previous hunt or capture had not
// finished. Assumes tick and slot come from the shared bit timer.
module pp_rx_burst #(
    parameter int B_BITS    = 16,
    parameter int D_BITS    = 2,
    parameter int HALF_BITS = 48,
    parameter int SW        = 7,
    parameter int SCR_LEN   = 23,
    parameter int SCR_TAP   = 5,
    localparam int PAY = B_BITS + D_BITS + 1,
    localparam int PW  = $clog2(PAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SW-1:0]     slot,
    input  logic              line_rx,
    output logic [B_BITS-1:0] rx_b,
    output logic [D_BITS-1:0] rx_d,
    output logic              rx_m,
    output logic              rx_valid,
    output logic              rx_lof
);
    import pp_pkg::*;

    rx_state_e      state_q;
    logic [PW-1:0]  pos_q;
    logic [PAY-1:0] cap_q, cap_n;
    logic           hunting, in_b, desc_out, rx_bit;

    // Hunt in HUNT state, or starting at the first receive slot.
    assign hunting = (state_q == RX_HUNT) ||
                     (state_q == RX_IDLE && slot == SW'(HALF_BITS));
    assign in_b    = (state_q == RX_CAPT) && (pos_q < PW'(B_BITS));

    pp_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b1)) u_desc (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (tick && slot != '0 && in_b),
        .din  (line_rx),
        .dout (desc_out)
    );

    // Payload bit to keep: descrambled in the B field, raw otherwise.
    assign rx_bit = in_b ? desc_out : line_rx;
    assign cap_n  = {rx_bit, cap_q[PAY-1:1]};

    // Burst hunt, capture and field delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            pos_q    <= '0;
            cap_q    <= '0;
            rx_b     <= '0;
            rx_d     <= '0;
            rx_m     <= 1'b0;
            rx_valid <= 1'b0;
            rx_lof   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick) begin
                if (slot == '0) begin
                    if (state_q == RX_HUNT || state_q == RX_CAPT)
                        rx_lof <= 1'b1;
                    state_q <= RX_IDLE;
                end else if (hunting) begin
                    if (line_rx) begin
                        state_q <= RX_CAPT;
                        pos_q   <= '0;
                    end else begin
                        state_q <= RX_HUNT;
                    end
                end else if (state_q == RX_CAPT) begin
                    cap_q <= cap_n;
                    pos_q <= pos_q + PW'(1);
                    if (pos_q == PW'(PAY - 1)) begin
                        state_q  <= RX_DONE;
                        rx_valid <= 1'b1;
                        rx_lof   <= 1'b0;
                        rx_b     <= cap_n[B_BITS-1:0];
                        rx_d     <= cap_n[B_BITS+D_BITS-1:B_BITS];
                        rx_m     <= cap_n[PAY-1];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pp_burst_framer.sv
// Module: top of the single-line ping-pong burst framer. It joins the slot
// timer, the transmit burst builder and the receive burst aligner.
// Assumes bit_en pulses once per line bit and frame_sync comes with bit_en.
module pp_burst_framer #(
    parameter int FRAME_BITS = pp_pkg::FRAME_BITS_DEF,
    parameter int HALF_BITS  = pp_pkg::HALF_BITS_DEF,
    parameter int B_BITS     = pp_pkg::B_BITS_DEF,
    parameter int D_BITS     = pp_pkg::D_BITS_DEF,
    parameter int SCR_LEN    = pp_pkg::SCR_LEN_DEF,
    parameter int SCR_TAP    = pp_pkg::SCR_TAP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_sync,
    input  logic [B_BITS-1:0] tx_b,
    input  logic [D_BITS-1:0] tx_d,
    input  logic              tx_m,
    output logic              line_tx,
    input  logic              line_rx,
    output logic [B_BITS-1:0] rx_b,
    output logic [D_BITS-1:0] rx_d,
    output logic              rx_m,
    output logic              rx_valid,
    output logic              rx_lof
);
    localparam int SW = $clog2(FRAME_BITS);

    logic          tick;
    logic [SW-1:0] slot;

    assign tick = bit_en;

    pp_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .frame_sync(frame_sync),
        .slot      (slot)
    );

    pp_tx_burst #(
        .B_BITS(B_BITS), .D_BITS(D_BITS), .SW(SW),
        .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .slot   (slot),
        .tx_b   (tx_b),
        .tx_d   (tx_d),
        .tx_m   (tx_m),
        .line_tx(line_tx)
    );

    pp_rx_burst #(
        .B_BITS(B_BITS), .D_BITS(D_BITS), .HALF_BITS(HALF_BITS), .SW(SW),
        .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .slot    (slot),
        .line_rx (line_rx),
        .rx_b    (rx_b),
        .rx_d    (rx_d),
        .rx_m    (rx_m),
        .rx_valid(rx_valid),
        .rx_lof  (rx_lof)
    );
endmodule

// File: rtl/pp_burst_framer_chk.sv
// Module: property checker for pp_burst_framer, attached by bind. It watches
// the slot timing, the quiet part of the transmit frame and the receive
// strobes. It drives nothing.
module pp_burst_framer_chk #(
    parameter int SW     = 7,
    parameter int B_BITS = 16,
    parameter int PAY    = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [SW-1:0]     slot,
    input logic              line_tx,
    input logic              rx_valid,
    input logic              rx_lof,
    input logic [B_BITS-1:0] rx_b
);
    AST_TX_FRAMING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick && slot == '0 |=> line_tx);                                  // R2
    AST_TX_QUIET_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tick && slot > SW'(PAY) |=> !line_tx);                            // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                          // R8
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick));                                        // R8
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_b));                                     // R8
    AST_LOF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_lof);                                            // R9
endmodule

bind pp_burst_framer pp_burst_framer_chk #(
    .SW(SW), .B_BITS(B_BITS), .PAY(B_BITS + D_BITS + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .slot    (slot),
    .line_tx (line_tx),
    .rx_valid(rx_valid),
    .rx_lof  (rx_lof),
    .rx_b    (rx_b)
);

// File: tb/pp_burst_framer_test.sv
// Directed bench for pp_burst_framer: each frame scenario loops the expected
// transmit burst back into the receive half with a chosen delay.
module pp_burst_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        frame_sync = 1'b0;
    logic [15:0] tx_b = '0;
    logic [1:0]  tx_d = '0;
    logic        tx_m = 1'b0;
    logic        line_tx;
    logic        line_rx = 1'b0;
    logic [15:0] rx_b;
    logic [1:0]  rx_d;
    logic        rx_m;
    logic        rx_valid;
    logic        rx_lof;

    int checks = 0;
    int fails  = 0;
    logic [22:0] tx_hist = '0;   // bench model of transmit scrambler history
    logic [22:0] rx_hist = '0;   // bench model of descrambler history
    logic        exp_lof = 1'b0;

    always #2.5 clk = ~clk;

    pp_burst_framer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
        .tx_b(tx_b), .tx_d(tx_d), .tx_m(tx_m), .line_tx(line_tx),
        .line_rx(line_rx), .rx_b(rx_b), .rx_d(rx_d), .rx_m(rx_m),
        .rx_valid(rx_valid), .rx_lof(rx_lof)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit period: raise bit_en on a falling edge, sample one clock later.
    task automatic drive_slot(input bit sync, input bit rxbit);
        @(negedge clk);
        bit_en = 1'b1; frame_sync = sync; line_rx = rxbit;
        @(negedge clk);
        bit_en = 1'b0; frame_sync = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(line_tx == 1'b0 && rx_valid == 1'b0 && rx_lof == 1'b0,
              "R10 reset controls", {29'd0, line_tx, rx_valid, rx_lof}, 32'd0);
        check(rx_b == '0 && rx_d == '0 && rx_m == 1'b0, "R10 reset fields",
              {13'd0, rx_m, rx_d, rx_b}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full frame: transmit b/d/m; receive the looped burst after dly slots.
    task automatic run_frame(input logic [15:0] b, input logic [1:0] d, input logic m,
                             input int dly, input bit noise, input bit nostart,
                             input bit want_plain);
        logic [95:0] exp_tx;
        logic [95:0] got_tx;
        logic [15:0] exp_b;
        logic        s, r;
        int          vcount, vslot, last;
        bit          exp_valid;
        exp_tx = '0;
        exp_tx[0] = 1'b1;
        for (int i = 0; i < 16; i++) begin
            s = b[i] ^ tx_hist[4] ^ tx_hist[22];
            tx_hist = {tx_hist[21:0], s};
            exp_tx[1 + i] = s;
        end
        exp_tx[17] = d[0];
        exp_tx[18] = d[1];
        exp_tx[19] = m;
        last = 48 + dly + 19;
        exp_valid = !nostart && last <= 95;
        exp_b = '0;
        if (!nostart) begin
            for (int i = 0; i < 16; i++) begin
                if (48 + dly + 1 + i <= 95) begin
                    r = exp_tx[1 + i];
                    exp_b[i] = r ^ rx_hist[4] ^ rx_hist[22];
                    rx_hist = {rx_hist[21:0], r};
                end
            end
        end
        tx_b = b; tx_d = d; tx_m = m;
        vcount = 0; vslot = -1; got_tx = '0;
        for (int sl = 0; sl < 96; sl++) begin
            logic rb;
            int   k;
            k = sl - 48 - dly;
            if (sl < 48) rb = noise;
            else if (!nostart && k >= 0 && k < 20) rb = exp_tx[k];
            else rb = 1'b0;
            drive_slot(sl == 0, rb);
            got_tx[sl] = line_tx;
            if (rx_valid) begin vcount++; vslot = sl; end
            if (sl == 0)
                check(rx_lof == exp_lof, "R9 lof at slot 0", {31'd0, rx_lof}, {31'd0, exp_lof});
            if (sl == 1) begin tx_b = ~b; tx_d = ~d; tx_m = ~m; end
        end
        check(got_tx[19:0] == exp_tx[19:0], "R1 R2 R3 R5 tx burst",
              {12'd0, got_tx[19:0]}, {12'd0, exp_tx[19:0]});
        check(got_tx[95:20] == '0, "R4 tx quiet tail",
              {31'd0, |got_tx[95:20]}, 32'd0);
        if (exp_valid) begin
            check(vcount == 1 && vslot == last, "R8 valid timing",
                  vslot, last);
            check(rx_b == exp_b && rx_d == d && rx_m == m, "R6 R7 rx fields",
                  {13'd0, rx_m, rx_d, rx_b}, {13'd0, m, d, exp_b});
            if (want_plain)
                check(rx_b == b, "R5 R7 plain B after reset", {16'd0, rx_b}, {16'd0, b});
            check(rx_lof == 1'b0, "R9 lof cleared", {31'd0, rx_lof}, 32'd0);
        end else begin
            check(vcount == 0, "R9 no valid on lost frame", vcount, 0);
        end
        exp_lof = !exp_valid;
    endtask

    initial begin
        test_reset();
        run_frame(16'hA5C3, 2'b01, 1'b1, 0,  1'b0, 1'b0, 1'b1);
        run_frame(16'h1234, 2'b10, 1'b0, 7,  1'b1, 1'b0, 1'b0);
        run_frame(16'hFFFF, 2'b11, 1'b1, 28, 1'b0, 1'b0, 1'b0);
        run_frame(16'h0F0F, 2'b00, 1'b0, 29, 1'b0, 1'b0, 1'b0);
        run_frame(16'h8001, 2'b01, 1'b1, 0,  1'b1, 1'b1, 1'b0);
        run_frame(16'h5A5A, 2'b10, 1'b1, 3,  1'b0, 1'b0, 1'b0);
        run_frame(16'h0000, 2'b00, 1'b0, 11, 1'b0, 1'b0, 1'b0);
        run_frame(16'hC0DE, 2'b11, 1'b0, 1,  1'b1, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule